// File: doc/BRIEF.md
# Leaf Page Permission Checker

This block judges a single memory access against the permission bits of a leaf page-table entry. It receives the entry's user, read, write and execute flags, the access class, the current privilege level (user or supervisor), and two status controls. One control, here called `mxr_i`, lets executable pages be read. The other, `sum_i`, lets supervisor code reach user pages with data accesses. From these it produces a grant, a fault code, and a flag that says whether the entry's dirty bit must be set.

Beside ordinary loads, stores, read-modify-write atomics and instruction fetches, the checker handles two cache-block maintenance classes. The data-side class needs the page to be writable or readable. The fetch-side class needs the page to be executable. Neither of them ever asks for the dirty bit, and both report their faults as store/AMO faults.

A page walker drives a request together with any walk failure it met. One clock later the checker returns a registered response. The page walk itself, the translation cache and the memory interface sit outside this block. A request made at machine level, or at the reserved level encoding, should never reach this checker. Such a request is refused, and it raises a sticky error that only reset clears.

Top module: `pte_perm_check`

## Requirements
- R1: At user level (`priv_i`=2'b00), with `pte_perm_i` bit 3 = U, bit 2 = X, bit 1 = W, bit 0 = R, the rules are: load (class 0) needs U and (R, or X with MXR); store (class 1) needs U and W; atomic (class 2) needs U, W and (R, or X with MXR); execute (class 3) needs U and X.
- R2: At supervisor level (`priv_i`=2'b01), a data access may reach the page when U is clear or SUM is set. With that reach: load needs R, or X with MXR; store needs W; atomic needs W and (R, or X with MXR). Execute needs U clear and X, and SUM has no effect on it.
- R3: A cache-block data access (class 4) is granted when the page is reachable and at least one of these holds: W, R, or X with MXR. At user level, reachable means U set. At supervisor level, it means U clear or SUM set.
- R4: A cache-block fetch access (class 5) is granted only for X with U set at user level, and only for X with U clear at supervisor level.
- R5: When `walk_fail_i` is high, `allow_o` is 0 and `fault_o` is 1. If `walk_acc_i` is 1 (access-type failure), the code is 5 for a load, 1 for an execute, and 7 for every other class. If `walk_acc_i` is 0 (page failure), the code is 13 for a load, 12 for an execute, and 15 for every other class, cache-block classes included.
- R6: A request with no walk failure that its rule denies gives `fault_o`=1 with the page-fault code of its class (13, 12 or 15). Classes 6 and 7 are never granted and report 15. A granted request gives `fault_o`=0 and `fault_code_o`=0.
- R7: `dirty_o` is 1 only for a granted store or atomic. It is never 1 for a load, an execute or either cache-block class.
- R8: A request at `priv_i` 2'b11 or 2'b10 gives `allow_o`=0, `fault_o`=0 and `dirty_o`=0, and sets `int_err_o`. `int_err_o` then stays 1 until reset, whatever later requests arrive.
- R9: Results are registered. The response to a request sampled at a rising edge appears on that edge, with `rsp_valid_o` high. In a cycle with no request, `rsp_valid_o`, `allow_o`, `fault_o`, `dirty_o` and `fault_code_o` are all 0.
- R10: A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| priv_i | input | 2 | Privilege: 00 user, 01 supervisor, 10 reserved, 11 machine |
| acc_class_i | input | 3 | 0 load, 1 store, 2 atomic, 3 execute, 4 cache-block data, 5 cache-block fetch, 6–7 unused |
| pte_perm_i | input | 4 | Leaf entry flags {U, X, W, R} |
| mxr_i | input | 1 | Executable pages are readable |
| sum_i | input | 1 | Supervisor may reach user pages for data |
| walk_fail_i | input | 1 | The page walk failed |
| walk_acc_i | input | 1 | Walk failure kind: 1 access failure, 0 page failure |
| rsp_valid_o | output | 1 | Registered response valid |
| allow_o | output | 1 | Access granted |
| fault_o | output | 1 | Access raises a fault |
| fault_code_o | output | CODE_W | Exception code of the fault, 0 when no fault |
| dirty_o | output | 1 | Dirty bit must be set |
| int_err_o | output | 1 | Sticky internal error from a request above supervisor level |

## Verification
Every result (grant, fault, code and dirty flag) is due exactly one rising edge after the request is sampled. The sticky error also rises on that same edge and stays high. The bench drives each request just after a falling edge and compares outputs at the next falling edge, which sits half a period after the capturing edge. No check depends on process order at the clock edge. The sweep covers every class, flag pattern, control setting and walk outcome at both legal privilege levels. After the sweep, the bench looks separately at idle cycles, error stickiness and reset clearing.

// File: rtl/pte_chk_pkg.sv
// Package: shared encodings and the permission rule for the leaf page
// permission checker. Assumes exception codes fit in 4 bits or more.
package pte_chk_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        ACC_LOAD  = 3'd0,
        ACC_STORE = 3'd1,
        ACC_AMO   = 3'd2,
        ACC_EXEC  = 3'd3,
        ACC_CBDAT = 3'd4,
        ACC_CBFET = 3'd5,
        ACC_RSV6  = 3'd6,
        ACC_RSV7  = 3'd7
    } acc_e;

    localparam int CLASS_W   = 3;
    localparam int NUM_CLASS = 1 << CLASS_W;
    localparam int PERM_W    = 4;

    // Leaf entry flags in the order {U, X, W, R}
    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
    } perm_t;

    // Architectural exception codes used by the checker
    localparam int EC_FETCH_ACC = 1;
    localparam int EC_LOAD_ACC  = 5;
    localparam int EC_STORE_ACC = 7;
    localparam int EC_FETCH_PG  = 12;
    localparam int EC_LOAD_PG   = 13;
    localparam int EC_STORE_PG  = 15;

    // Rule for one access class at user or supervisor level
    function automatic logic class_rule(
        input logic [CLASS_W-1:0] cls,
        input logic               is_user,
        input perm_t              p,
        input logic               mxr,
        input logic               sum
    );
        logic data_reach;
        logic code_reach;
        logic readable;
        logic ok;
        data_reach = is_user ? p.u : (!p.u || sum);
        code_reach = is_user ? p.u : !p.u;
        readable   = p.r || (p.x && mxr);
        case (acc_e'(cls))
            ACC_LOAD:  ok = data_reach && readable;
            ACC_STORE: ok = data_reach && p.w;
            ACC_AMO:   ok = data_reach && p.w && readable;
            ACC_EXEC:  ok = code_reach && p.x;
            ACC_CBDAT: ok = data_reach && (p.w || readable);
            ACC_CBFET: ok = code_reach && p.x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pte_rule_eval.sv
// Module: evaluates every access-class rule in parallel for the presented
// entry and privilege, then selects the requested class. Assumes priv_i
// levels other than user/supervisor are flagged by priv_ok_o, not granted.
module pte_rule_eval
    import pte_chk_pkg::*;
(
    input  logic [1:0]         priv_i,
    input  logic [CLASS_W-1:0] cls_i,
    input  logic [PERM_W-1:0]  perm_i,
    input  logic               mxr_i,
    input  logic               sum_i,
    output logic               grant_o,
    output logic               priv_ok_o
);

    perm_t                p;
    logic                 is_user;
    logic [NUM_CLASS-1:0] per_class;

    assign p       = perm_t'(perm_i);
    assign is_user = (priv_i == PRIV_USER);

    // One rule evaluator per access class
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        assign per_class[c] = class_rule(CLASS_W'(c), is_user, p, mxr_i, sum_i);
    end

    // Select the requested class and gate it with a legal privilege
    always_comb begin
        priv_ok_o = (priv_i == PRIV_USER) || (priv_i == PRIV_SUPER);
        grant_o   = priv_ok_o && per_class[cls_i];
    end

endmodule

// File: rtl/pte_fault_map.sv
// Module: turns a walk outcome and a rule verdict into a fault flag and an
// exception code. Assumes grant_i already includes the privilege check.
module pte_fault_map
    import pte_chk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic [CLASS_W-1:0] cls_i,
    input  logic               priv_ok_i,
    input  logic               grant_i,
    input  logic               walk_fail_i,
    input  logic               walk_acc_i,
    output logic               fault_o,
    output logic [CODE_W-1:0]  code_o
);

    logic is_access;

    // Choose the fault kind and the code family of the class
    always_comb begin
        fault_o   = priv_ok_i && (walk_fail_i || !grant_i);
        is_access = walk_fail_i && walk_acc_i;
        code_o    = '0;
        if (fault_o) begin
            case (acc_e'(cls_i))
                ACC_LOAD: code_o = is_access ? CODE_W'(EC_LOAD_ACC)  : CODE_W'(EC_LOAD_PG);
                ACC_EXEC: code_o = is_access ? CODE_W'(EC_FETCH_ACC) : CODE_W'(EC_FETCH_PG);
                default:  code_o = is_access ? CODE_W'(EC_STORE_ACC) : CODE_W'(EC_STORE_PG);
            endcase
        end
    end

endmodule

// File: rtl/pte_perm_check.sv
// Module: top of the leaf page permission checker. Combines the rule
// evaluator and fault mapper, adds the dirty policy and registers every
// result one cycle after the request. Requests above supervisor level set
// a sticky internal error. Assumes a synchronous active-low reset.
module pte_perm_check
    import pte_chk_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        priv_i,
    input  logic [2:0]        acc_class_i,
    input  logic [3:0]        pte_perm_i,
    input  logic              mxr_i,
    input  logic              sum_i,
    input  logic              walk_fail_i,
    input  logic              walk_acc_i,
    output logic              rsp_valid_o,
    output logic              allow_o,
    output logic              fault_o,
    output logic [CODE_W-1:0] fault_code_o,
    output logic              dirty_o,
    output logic              int_err_o
);

    logic              grant;
    logic              priv_ok;
    logic              fault_c;
    logic [CODE_W-1:0] code_c;
    logic              allow_c;
    logic              dirty_c;

    pte_rule_eval u_rule (
        .priv_i   (priv_i),
        .cls_i    (acc_class_i),
        .perm_i   (pte_perm_i),
        .mxr_i    (mxr_i),
        .sum_i    (sum_i),
        .grant_o  (grant),
        .priv_ok_o(priv_ok)
    );

    pte_fault_map #(.CODE_W(CODE_W)) u_fault (
        .cls_i      (acc_class_i),
        .priv_ok_i  (priv_ok),
        .grant_i    (grant),
        .walk_fail_i(walk_fail_i),
        .walk_acc_i (walk_acc_i),
        .fault_o    (fault_c),
        .code_o     (code_c)
    );

    // Final grant and dirty policy: only granted stores and atomics dirty
    always_comb begin
        allow_c = grant && !walk_fail_i;
        dirty_c = allow_c && ((acc_class_i == ACC_STORE) || (acc_class_i == ACC_AMO));
    end

    // Response registers, cleared in idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o  <= 1'b0;
            allow_o      <= 1'b0;
            fault_o      <= 1'b0;
            fault_code_o <= '0;
            dirty_o      <= 1'b0;
        end else begin
            rsp_valid_o  <= req_valid_i;
            allow_o      <= req_valid_i && allow_c;
            fault_o      <= req_valid_i && fault_c;
            fault_code_o <= req_valid_i ? code_c : '0;
            dirty_o      <= req_valid_i && dirty_c;
        end
    end

    // Sticky internal error for requests above supervisor level
    always_ff @(posedge clk) begin
        if (!rst_n)                       int_err_o <= 1'b0;
        else if (req_valid_i && !priv_ok) int_err_o <= 1'b1;
    end

    assert_sticky_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_err_o |=> int_err_o);

    assert_mach_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && priv_i[1]) |=> (!allow_o && !fault_o && !dirty_o && int_err_o));

    assert_grant_nofault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        allow_o |-> (!fault_o && fault_code_o == '0));

    assert_dirty_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_o |-> allow_o);

    assert_cbo_nodirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (acc_class_i == ACC_CBDAT || acc_class_i == ACC_CBFET)) |=> !dirty_o);

    assert_walk_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && walk_fail_i && !priv_i[1]) |=> (!allow_o && fault_o));

    assert_cbf_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && acc_class_i == ACC_CBFET && !pte_perm_i[2]) |=> !allow_o);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !allow_o && !fault_o && !dirty_o));

endmodule

// File: tb/sim_pte_perm_check.sv
module sim_pte_perm_check;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    priv;
    logic [2:0]    cls;
    logic [3:0]    perm;
    logic          mxr, sum, wf, wacc;
    logic          rsp_valid, allow, fault, dirty, int_err;
    logic [CW-1:0] code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pte_perm_check #(.CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .priv_i(priv),
        .acc_class_i(cls), .pte_perm_i(perm), .mxr_i(mxr), .sum_i(sum),
        .walk_fail_i(wf), .walk_acc_i(wacc), .rsp_valid_o(rsp_valid),
        .allow_o(allow), .fault_o(fault), .fault_code_o(code),
        .dirty_o(dirty), .int_err_o(int_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected grant from the written rules, U=p[3] X=p[2] W=p[1] R=p[0]
    function automatic bit exp_rule(input int pv, input int c, input logic [3:0] p,
                                    input bit m, input bit s);
        bit u = p[3], x = p[2], w = p[1], r = p[0];
        bit rd = r | (x & m);
        if (pv == 0) begin
            case (c)
                0: return u & rd;
                1: return u & w;
                2: return u & w & rd;
                3: return u & x;
                4: return u & (w | rd);
                5: return u & x;
                default: return 0;
            endcase
        end
        case (c)
            0: return (!u | s) & rd;
            1: return (!u | s) & w;
            2: return (!u | s) & w & rd;
            3: return !u & x;
            4: return (!u | s) & (w | rd);
            5: return !u & x;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_code(input int c, input bit f, input bit a);
        if (f && a) return (c == 0) ? 5 : (c == 3) ? 1 : 7;
        return (c == 0) ? 13 : (c == 3) ? 12 : 15;
    endfunction

    task automatic drive(input bit v, input int pv, input int c, input int p,
                         input bit m, input bit s, input bit f, input bit a);
        req_valid = v; priv = 2'(pv); cls = 3'(c); perm = 4'(p);
        mxr = m; sum = s; wf = f; wacc = a;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1, 3, 1, 15, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        // R10: reset state, even with a machine request held on the inputs
        chk("R10", "rsp_valid", int'(rsp_valid), 0);
        chk("R10", "allow", int'(allow), 0);
        chk("R10", "fault", int'(fault), 0);
        chk("R10", "code", int'(code), 0);
        chk("R10", "dirty", int'(dirty), 0);
        chk("R10", "int_err", int'(int_err), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle after reset keeps outputs low
        chk("R9", "idle rsp_valid", int'(rsp_valid), 0);

        // Exhaustive sweep at user and supervisor levels
        for (int pv = 0; pv < 2; pv++)
        for (int c = 0; c < 8; c++)
        for (int p = 0; p < 16; p++)
        for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++)
        for (int f = 0; f < 2; f++)
        for (int a = 0; a < 2; a++) begin
            bit ok, eal, efa, edi;
            int ecd;
            string rt, ft;
            drive(1, pv, c, p, m[0], s[0], f[0], a[0]);
            ok  = exp_rule(pv, c, 4'(p), m[0], s[0]);
            eal = ok & !f[0];
            efa = !eal;
            ecd = efa ? exp_code(c, f[0], a[0]) : 0;
            edi = eal & (c == 1 || c == 2);
            rt  = (c == 4) ? "R3" : (c == 5) ? "R4" : (c > 5) ? "R6" : (pv == 0) ? "R1" : "R2";
            ft  = f[0] ? "R5" : "R6";
            @(negedge clk);
            chk("R9", "rsp_valid", int'(rsp_valid), 1);
            chk(rt, $sformatf("allow pv=%0d c=%0d p=%0d m=%0d s=%0d f=%0d", pv, c, p, m, s, f),
                int'(allow), int'(eal));
            chk(ft, $sformatf("fault/code c=%0d p=%0d f=%0d a=%0d", c, p, f, a),
                int'({fault, code}), int'({efa, 5'(ecd)}));
            chk("R7", $sformatf("dirty c=%0d p=%0d", c, p), int'(dirty), int'(edi));
        end
        chk("R8", "int_err low after legal sweep", int'(int_err), 0);

        // R9: idle cycle after a granted store clears the response
        drive(1, 0, 1, 15, 0, 0, 0, 0);
        @(negedge clk);
        chk("R7", "granted store dirty", int'(dirty), 1);
        drive(0, 0, 1, 15, 0, 0, 0, 0);
        @(negedge clk);
        chk("R9", "idle rsp_valid", int'(rsp_valid), 0);
        chk("R9", "idle allow", int'(allow), 0);
        chk("R9", "idle dirty", int'(dirty), 0);

        // R8: machine request is refused and sets the sticky error
        drive(1, 3, 1, 15, 1, 1, 0, 0);
        @(negedge clk);
        chk("R8", "machine allow", int'(allow), 0);
        chk("R8", "machine fault", int'(fault), 0);
        chk("R8", "machine dirty", int'(dirty), 0);
        chk("R8", "machine int_err", int'(int_err), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R8", "int_err sticky over idle", int'(int_err), 1);
        drive(1, 0, 0, 9, 0, 0, 0, 0);
        @(negedge clk);
        chk("R8", "legal request after error still granted", int'(allow), 1);
        chk("R8", "int_err sticky over legal request", int'(int_err), 1);

        // R8: reserved level also raises the error (after a reset clears it)
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10", "reset clears int_err", int'(int_err), 0);
        rst_n = 1'b1;
        drive(1, 2, 4, 15, 1, 1, 1, 1);
        @(negedge clk);
        chk("R8", "reserved level allow", int'(allow), 0);
        chk("R8", "reserved level fault", int'(fault), 0);
        chk("R8", "reserved level int_err", int'(int_err), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule